// File: doc/BRIEF.md
# Four-Channel Lamp Pattern Sequencer

This block drives four on/off lamp channels. A free-running base tick feeds a step countdown. Its reload value comes from one of four speed settings. Each time the countdown expires, the block moves one step through the pattern of the current mode. Six modes play fixed patterns of different lengths. A seventh mode takes its channel word from a 16-bit shift-register generator.

Mode 0 is a manual mode. In it, each of four debounced button levels turns its own channel on. Button changes arrive as already-decoded events, each carrying a type and a switch index. One switch cycles through the modes. Two other switches step the speed up and down, and the speed wraps at both ends. The channel word is registered and goes straight to the lamp drivers.

Top module: `lamp_sequencer`

## Requirements
- R1: Synchronous active-high reset leaves the channel word at 0. It also sets mode 0, speed index 0 and pattern step 0, and loads the countdown with the speed-0 reload count.
- R2: The countdown changes only in cycles with the base tick high. On such a tick it decrements, except that a tick seen while it holds 1 raises a step request and reloads it. The reload count belongs to the speed index in force before that clock edge. Reload counts for speed index 0 to 3 are 19531, 9766, 4883 and 2441 by default.
- R3: On a step in a pattern mode, the channel word takes the table entry at the current step, and the step then advances. After the last entry of that mode it returns to 0. The tables, with channel i on bit i, are: mode 0 {0}; mode 1 {1,2,4,8}; mode 2 {1,2,4,8,4,2}; mode 3 {0,1,3,7,F,7,3,1}; mode 4 {3,C}; mode 5 {5,A}.
- R4: An event of type 1 (press) on switch 4 advances the mode by one, wrapping from 6 to 0. In that same cycle it clears the channel word and the step. An event of type 2 (release) on switch 4 changes nothing.
- R5: In modes 1 to 6, a press on switch 1 raises the speed index, wrapping 3 to 0, and a press on switch 0 lowers it, wrapping 0 to 3. Releases, and events on switches 2 and 3, leave the speed unchanged.
- R6: In mode 0, each button level i that is high forces channel bit i on from the next edge. A release event on switch i (0 to 3) clears bit i in that same cycle.
- R7: In mode 0, presses on switches 0 and 1 leave the speed index unchanged.
- R8: The generator is seeded with 0x5A0B at reset. One advance shifts it right by one bit and, if the bit shifted out was 1, XORs it with 0xB400. In mode 6, each step advances it four times and puts its low 4 bits on the channels. Without a step it holds.
- R9: A mode-advance event and a step request in the same cycle are both applied. The channel word takes entry 0 of the new mode, the step becomes 1 (or 0 for a one-entry pattern), and the mode-0 override is applied last.
- R10: Outside mode 0, the channel word holds in every cycle that has neither a step request nor a mode advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baseTick | input | 1 | Single-cycle base timing tick |
| evValid | input | 1 | Button event strobe |
| evType | input | 4 | Event type: 1 press, 2 release |
| evSwitch | input | 4 | Switch index of the event |
| btnLevel | input | 4 | Debounced levels of buttons 0 to 3 |
| chanOut | output | 4 | Registered lamp channel word, bit i is channel i |

## Verification
The hardest case to reach is a mode-advance press that lands exactly on the tick that expires the countdown. Here the mode change, the step reset and the table lookup of the new mode all fall on the same edge. The bench keeps its own arithmetic model of the countdown, so it can fire the press on that tick, at several speeds and into several modes, including the wrap from the random mode back to mode 0. Speed wrap in both directions is also reached only through sequences of presses. The bench verifies each speed change by the spacing of the following steps on the channel word.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int NUM_CH    = 4;
  localparam int NUM_MODES = 7;
  localparam int MODE_W    = $clog2(NUM_MODES);
  localparam int NUM_SPEED = 4;
  localparam int SPEED_W   = $clog2(NUM_SPEED);
  localparam int STEP_W    = 3;
  localparam int LFSR_W    = 16;
  localparam int EVT_W     = 4;

  localparam logic [MODE_W-1:0] MODE_MANUAL = '0;
  localparam logic [MODE_W-1:0] MODE_RANDOM = MODE_W'(NUM_MODES - 1);
  localparam logic [EVT_W-1:0]  EV_PRESS    = 4'd1;
  localparam logic [EVT_W-1:0]  EV_RELEASE  = 4'd2;
  localparam logic [EVT_W-1:0]  SW_MODE     = 4'd4;
  localparam logic [EVT_W-1:0]  SW_SLOWER   = 4'd0;
  localparam logic [EVT_W-1:0]  SW_FASTER   = 4'd1;
  localparam logic [LFSR_W-1:0] LFSR_TOGGLE = 16'hB400;

  typedef struct packed {
    logic              stepReq;
    logic              modeAdv;
    logic [NUM_CH-1:0] clrMask;
    logic [MODE_W-1:0] nextMode;
  } seqStrobes_t;

  function automatic logic [STEP_W:0] patternLen(input logic [MODE_W-1:0] m);
    case (m)
      3'd1:    patternLen = 4'd4;
      3'd2:    patternLen = 4'd6;
      3'd3:    patternLen = 4'd8;
      3'd4:    patternLen = 4'd2;
      3'd5:    patternLen = 4'd2;
      default: patternLen = 4'd1;
    endcase
  endfunction

  function automatic logic [NUM_CH-1:0] patternEntry(input logic [MODE_W-1:0] m,
                                                     input logic [STEP_W-1:0] s);
    logic [NUM_CH-1:0] v;
    v = '0;
    case (m)
      3'd1: case (s)
              3'd0: v = 4'h1; 3'd1: v = 4'h2; 3'd2: v = 4'h4; default: v = 4'h8;
            endcase
      3'd2: case (s)
              3'd0: v = 4'h1; 3'd1: v = 4'h2; 3'd2: v = 4'h4;
              3'd3: v = 4'h8; 3'd4: v = 4'h4; default: v = 4'h2;
            endcase
      3'd3: case (s)
              3'd0: v = 4'h0; 3'd1: v = 4'h1; 3'd2: v = 4'h3; 3'd3: v = 4'h7;
              3'd4: v = 4'hF; 3'd5: v = 4'h7; 3'd6: v = 4'h3; default: v = 4'h1;
            endcase
      3'd4: v = (s == 3'd0) ? 4'h3 : 4'hC;
      3'd5: v = (s == 3'd0) ? 4'h5 : 4'hA;
      default: v = 4'h0;
    endcase
    return v;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsrAdvance(input logic [LFSR_W-1:0] r);
    logic [LFSR_W-1:0] n;
    n = r >> 1;
    if (r[0]) n = n ^ LFSR_TOGGLE;
    return n;
  endfunction
endpackage

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RELOAD0 = 19531,
  parameter int RELOAD1 = 9766,
  parameter int RELOAD2 = 4883,
  parameter int RELOAD3 = 2441
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baseTick,
  input  logic               evValid,
  input  logic [EVT_W-1:0]   evType,
  input  logic [EVT_W-1:0]   evSwitch,
  output logic [MODE_W-1:0]  modeQ,
  output logic [SPEED_W-1:0] speedQ,
  output seqStrobes_t        strobes
);
  localparam logic [CNT_W-1:0] RELOAD_TAB [NUM_SPEED] = '{
    CNT_W'(RELOAD0), CNT_W'(RELOAD1), CNT_W'(RELOAD2), CNT_W'(RELOAD3)
  };
  localparam logic [SPEED_W-1:0] SPEED_MAX = SPEED_W'(NUM_SPEED - 1);

  logic [CNT_W-1:0] cntQ;
  logic isPress, isRelease, speedUp, speedDown, expire;

  assign isPress   = evValid && (evType == EV_PRESS);
  assign isRelease = evValid && (evType == EV_RELEASE);
  assign expire    = baseTick && (cntQ == CNT_W'(1));
  assign speedUp   = isPress && (modeQ != MODE_MANUAL) && (evSwitch == SW_FASTER);
  assign speedDown = isPress && (modeQ != MODE_MANUAL) && (evSwitch == SW_SLOWER);

  assign strobes.stepReq  = expire;
  assign strobes.modeAdv  = isPress && (evSwitch == SW_MODE);
  assign strobes.nextMode = (modeQ == MODE_RANDOM) ? MODE_MANUAL : modeQ + MODE_W'(1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    assign strobes.clrMask[i] = isRelease && (modeQ == MODE_MANUAL)
                                && (evSwitch == EVT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= RELOAD_TAB[0];
    end else if (baseTick) begin
      cntQ <= expire ? RELOAD_TAB[speedQ] : cntQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_MANUAL;
    end else if (strobes.modeAdv) begin
      modeQ <= strobes.nextMode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      speedQ <= '0;
    end else if (speedUp) begin
      speedQ <= (speedQ == SPEED_MAX) ? '0 : speedQ + SPEED_W'(1);
    end else if (speedDown) begin
      speedQ <= (speedQ == '0) ? SPEED_MAX : speedQ - SPEED_W'(1);
    end
  end
endmodule

// File: rtl/lseq_datapath.sv
module lseq_datapath
  import lseq_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h5A0B,
  parameter int                LFSR_ADV  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [MODE_W-1:0] modeQ,
  input  logic [NUM_CH-1:0] btnLevel,
  output logic [NUM_CH-1:0] chanOut
);
  logic [STEP_W-1:0] stepQ, stepNext, effStep;
  logic [MODE_W-1:0] effMode;
  logic [LFSR_W-1:0] lfsrQ, lfsrRun, lfsrNext;
  logic [NUM_CH-1:0] outQ, outNext;
  logic [STEP_W:0]   lenNow;

  assign effMode = strobes.modeAdv ? strobes.nextMode : modeQ;
  assign effStep = strobes.modeAdv ? '0 : stepQ;
  assign lenNow  = patternLen(effMode);

  always_comb begin
    lfsrRun = lfsrQ;
    for (int k = 0; k < LFSR_ADV; k++) lfsrRun = lfsrAdvance(lfsrRun);
  end

  always_comb begin
    outNext  = strobes.modeAdv ? '0 : outQ;
    outNext  = outNext & ~strobes.clrMask;
    stepNext = effStep;
    lfsrNext = lfsrQ;
    if (strobes.stepReq) begin
      if (effMode == MODE_RANDOM) begin
        outNext  = lfsrRun[NUM_CH-1:0];
        lfsrNext = lfsrRun;
      end else begin
        outNext = patternEntry(effMode, effStep);
      end
      stepNext = ({1'b0, effStep} >= lenNow - 1'b1) ? '0 : effStep + STEP_W'(1);
    end
    if (effMode == MODE_MANUAL) outNext = outNext | btnLevel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= '0;
      outQ  <= '0;
      lfsrQ <= LFSR_SEED;
    end else begin
      stepQ <= stepNext;
      outQ  <= outNext;
      lfsrQ <= lfsrNext;
    end
  end

  assign chanOut = outQ;
endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer
  import lseq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RELOAD0 = 19531,
  parameter int RELOAD1 = 9766,
  parameter int RELOAD2 = 4883,
  parameter int RELOAD3 = 2441
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baseTick,
  input  logic       evValid,
  input  logic [3:0] evType,
  input  logic [3:0] evSwitch,
  input  logic [3:0] btnLevel,
  output logic [3:0] chanOut
);
  seqStrobes_t        strobes;
  logic [MODE_W-1:0]  modeQ;
  logic [SPEED_W-1:0] speedQ;

  lseq_ctrl #(
    .CNT_W(CNT_W), .RELOAD0(RELOAD0), .RELOAD1(RELOAD1),
    .RELOAD2(RELOAD2), .RELOAD3(RELOAD3)
  ) u_ctrl (
    .clk(clk), .rst(rst), .baseTick(baseTick), .evValid(evValid),
    .evType(evType), .evSwitch(evSwitch), .modeQ(modeQ),
    .speedQ(speedQ), .strobes(strobes)
  );

  lseq_datapath u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .modeQ(modeQ),
    .btnLevel(btnLevel), .chanOut(chanOut)
  );
endmodule

// File: rtl/lseq_checker.sv
module lseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       evValid,
  input logic [3:0] evType,
  input logic [3:0] evSwitch,
  input logic [3:0] btnLevel,
  input logic [3:0] chanOut,
  input logic [2:0] modeQ,
  input logic [1:0] speedQ,
  input logic       stepReq
);
  logic advNow;
  assign advNow = evValid && evType == 4'd1 && evSwitch == 4'd4;

  assert_mode_range_R4: assert property (@(posedge clk) disable iff (rst)
    modeQ <= 3'd6);

  assert_mode_step_R4: assert property (@(posedge clk) disable iff (rst)
    advNow |=> modeQ == (($past(modeQ) == 3'd6) ? 3'd0 : $past(modeQ) + 3'd1));

  assert_adv_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (advNow && !stepReq && modeQ != 3'd6) |=> chanOut == 4'd0);

  assert_speed_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !evValid |=> $stable(speedQ));

  assert_speed_manual_R7: assert property (@(posedge clk) disable iff (rst)
    (modeQ == 3'd0) |=> $stable(speedQ));

  assert_override_R6: assert property (@(posedge clk) disable iff (rst)
    (modeQ == 3'd0 && !advNow) |=> (chanOut & $past(btnLevel)) == $past(btnLevel));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (modeQ != 3'd0 && !stepReq && !advNow) |=> $stable(chanOut));
endmodule

bind lamp_sequencer lseq_checker u_lseq_checker (
  .clk(clk), .rst(rst), .evValid(evValid), .evType(evType),
  .evSwitch(evSwitch), .btnLevel(btnLevel), .chanOut(chanOut),
  .modeQ(modeQ), .speedQ(speedQ), .stepReq(strobes.stepReq)
);

// File: tb/lamp_sequencer_bench.sv
module lamp_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RL0 = 4, RL1 = 3, RL2 = 2, RL3 = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baseTick = 1'b0, evValid = 1'b0;
  logic [3:0] evType = '0, evSwitch = '0, btnLevel = '0;
  logic [3:0] chanOut;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  int mMode, mSpeed, mCnt, mStep;
  logic [3:0]  mOut;
  logic [15:0] mLfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lamp_sequencer #(.CNT_W(8), .RELOAD0(RL0), .RELOAD1(RL1), .RELOAD2(RL2),
                   .RELOAD3(RL3)) u_lamp_sequencer (
    .clk(clk), .rst(rst), .baseTick(baseTick), .evValid(evValid),
    .evType(evType), .evSwitch(evSwitch), .btnLevel(btnLevel), .chanOut(chanOut));

  function automatic int reloadOf(int s);
    return (s == 0) ? RL0 : (s == 1) ? RL1 : (s == 2) ? RL2 : RL3;
  endfunction
  function automatic int lenOf(int m);
    return (m == 1) ? 4 : (m == 2) ? 6 : (m == 3) ? 8 : (m == 4 || m == 5) ? 2 : 1;
  endfunction
  function automatic logic [3:0] patOf(int m, int s);
    case (m)
      1: return 4'(1 << s);
      2: return (s < 4) ? 4'(1 << s) : 4'(1 << (6 - s));
      3: return (s <= 4) ? 4'((1 << s) - 1) : 4'((1 << (8 - s)) - 1);
      4: return (s == 0) ? 4'h3 : 4'hC;
      5: return (s == 0) ? 4'h5 : 4'hA;
      default: return 4'h0;
    endcase
  endfunction

  task automatic modelEdge();
    bit press, rel, adv, sr;
    int em, es;
    logic [3:0] o;
    if (rst) begin
      mMode = 0; mSpeed = 0; mCnt = RL0; mStep = 0; mOut = 0; mLfsr = 16'h5A0B;
      return;
    end
    press = evValid && evType == 4'd1;
    rel   = evValid && evType == 4'd2;
    adv   = press && evSwitch == 4'd4;
    sr    = baseTick && mCnt == 1;
    if (baseTick) mCnt = sr ? reloadOf(mSpeed) : mCnt - 1;
    o = mOut; em = mMode; es = mStep;
    if (adv) begin em = (mMode + 1) % 7; es = 0; o = 0; end
    if (rel && mMode == 0 && evSwitch < 4) o[evSwitch[1:0]] = 1'b0;
    if (press && mMode != 0 && evSwitch == 4'd1) mSpeed = (mSpeed + 1) % 4;
    if (press && mMode != 0 && evSwitch == 4'd0) mSpeed = (mSpeed + 3) % 4;
    if (sr) begin
      if (em == 6) begin
        for (int k = 0; k < 4; k++)
          mLfsr = (mLfsr >> 1) ^ (mLfsr[0] ? 16'hB400 : 16'h0000);
        o = mLfsr[3:0];
      end else o = patOf(em, es);
      es = (es + 1) % lenOf(em);
    end
    if (em == 0) o = o | btnLevel;
    mMode = em; mStep = es; mOut = o;
  endtask

  task automatic cyc(input logic tk, input logic ev, input logic [3:0] ty,
                     input logic [3:0] sw);
    baseTick = tk; evValid = ev; evType = ty; evSwitch = sw;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    total++;
    if (chanOut !== mOut) begin
      bad++;
      $display("FAIL %s: chanOut=%h expected=%h (mode %0d)", tag, chanOut, mOut, mMode);
    end
    baseTick = 1'b0; evValid = 1'b0;
  endtask

  task automatic idle(input int n, input int tickEvery);
    for (int i = 0; i < n; i++) cyc((i % tickEvery) == 0, 1'b0, 4'd0, 4'd0);
  endtask

  task automatic press(input logic [3:0] sw, input logic tk);
    cyc(tk, 1'b1, 4'd1, sw);
  endtask

  task automatic toMode(input int m);
    while (mMode != m) press(4'd4, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 4'd0, 4'd0);
    rst = 1'b0;
    idle(10, 1);

    tag = "R6";
    for (int b = 0; b < 16; b++) begin
      btnLevel = 4'(b);
      idle(3, 2);
    end
    btnLevel = 4'hF; idle(2, 5);
    for (int s = 0; s < 4; s++) begin
      btnLevel[s] = 1'b0;
      cyc(1'b0, 1'b1, 4'd2, 4'(s));
      idle(2, 7);
    end
    btnLevel = 4'h5; idle(2, 9);
    btnLevel = 4'h0; idle(6, 1);

    tag = "R7";
    press(4'd1, 1'b1); press(4'd1, 1'b0); press(4'd0, 1'b1);
    idle(3, 1);

    tag = "R3";
    for (int m = 1; m <= 5; m++) begin
      toMode(m);
      idle(40, 1);
      idle(30, 3);
    end

    tag = "R5";
    toMode(2);
    for (int i = 0; i < 5; i++) begin press(4'd1, 1'b1); idle(12, 1); end
    for (int i = 0; i < 6; i++) begin press(4'd0, 1'b1); idle(12, 1); end
    cyc(1'b1, 1'b1, 4'd2, 4'd1); idle(8, 1);
    cyc(1'b1, 1'b1, 4'd2, 4'd0); idle(8, 1);
    press(4'd2, 1'b1); press(4'd3, 1'b1); idle(8, 1);

    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      press(4'd1, 1'b1);
      idle(20, 1);
      idle(20, 2);
    end

    tag = "R10";
    toMode(3);
    idle(15, 100);
    cyc(1'b0, 1'b1, 4'd2, 4'd4);
    idle(5, 100);

    tag = "R8";
    toMode(6);
    for (int s = 0; s < 4; s++) begin
      press(4'd1, 1'b0);
      idle(30, 1);
    end

    tag = "R9";
    for (int r = 0; r < 14; r++) begin
      if (r % 3 == 0) press(4'd0, 1'b0);
      while (mCnt != 1) cyc(1'b1, 1'b0, 4'd0, 4'd0);
      btnLevel = (mMode == 6) ? 4'h2 : 4'h0;
      press(4'd4, 1'b1);
      idle(4, 1);
      btnLevel = 4'h0;
      idle(3, 1);
    end

    tag = "R4";
    toMode(6);
    idle(5, 1);
    cyc(1'b1, 1'b1, 4'd2, 4'd4);
    press(4'd4, 1'b0);
    idle(6, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule